// File: doc/BRIEF.md
# Parallel-to-Serial Shift Register

This block is a small register that captures a parallel word and then streams it out one bit per clock, least significant bit first. Each clock it either keeps its contents, takes a fresh parallel word, or moves every bit one place toward bit 0. During a move the top bit is filled from a serial input, and bit 0 is always visible on a serial output pin. The word therefore leaves in bit-reversed order compared with how it is read in parallel.

Two enables pick the action. With both low the contents stay put. A load enable alone captures the parallel word. A shift enable moves the bits whatever the load enable is doing, so shift wins when both are high. An active-low clear empties the register at once, without waiting for a clock edge. Its release passes through a short synchronizer, so the register stays cleared for a fixed number of edges after the pin goes high. The width defaults to four bits and is a parameter.

Top module: `piso_shift_reg`

## Requirements
- R1: While `clr_n` is low, `par_out` is all zeros, and it goes to zero as soon as `clr_n` falls, with no clock edge needed.
- R2: On a rising edge with `shift_en`=0 and `load_en`=0, `par_out` keeps its value.
- R3: On a rising edge with `shift_en`=0 and `load_en`=1, `par_out` takes the value of `par_in`.
- R4: On a rising edge with `shift_en`=1, bit i of `par_out` takes the old bit i+1, and the top bit takes `ser_in`.
- R5: When `shift_en` and `load_en` are both 1, the register shifts as in R4 and ignores `par_in`.
- R6: `ser_out` always equals bit 0 of `par_out`, with no added delay, so the first serial bit is valid straight after the load edge.
- R7: Loading 4'b1011 and then shifting four times with `ser_in`=0 gives `ser_out` values 1,1,0,1 and top-bit values 1,0,0,0. Each value is read after the load and after each of the first three shifts.
- R8: After `clr_n` rises, the register ignores the first two rising edges (SYNC_STAGES=2) and stays at zero. It acts on its enables from the third edge on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| clr_n | input | 1 | Active-low clear: asserts asynchronously, releases through the synchronizer |
| shift_en | input | 1 | Shift one place toward bit 0; takes priority over load |
| load_en | input | 1 | Capture `par_in` when no shift is requested |
| par_in | input | WIDTH | Parallel data word |
| ser_in | input | 1 | Serial bit that enters the top position on a shift |
| par_out | output | WIDTH | Current register contents |
| ser_out | output | 1 | Serial output, equal to bit 0 of the register |

## Verification
The bench raises both enables together while driving a `par_in` that differs from the shift result. A design that let load win would show the parallel word instead of the shifted one. It also holds `load_en` high across the release of the clear. A design with a missing or short synchronizer would capture the word one or two edges too early, and one with a long synchronizer would capture it too late. The clear is pulsed between edges, so a synchronous-only clear would leave stale data visible. The bench also runs a full four-shift serialisation with varied `ser_in` values and checks `ser_out` straight after the load edge. That catches a swapped shift direction, a registered serial output, or a top bit fed from the wrong source.

// File: rtl/piso_pkg.sv
package piso_pkg;

  typedef enum logic [1:0] {
    ACT_HOLD  = 2'b00,
    ACT_LOAD  = 2'b01,
    ACT_SHIFT = 2'b10
  } piso_act_e;

endpackage

// File: rtl/piso_rst_sync.sv
module piso_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic clr_n,
  output logic rst_n_sync
);

  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge clr_n) begin
    if (!clr_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_sync = chain_q[STAGES-1];

endmodule

// File: rtl/piso_ctrl.sv
module piso_ctrl
  import piso_pkg::*;
(
  input  logic      shift_en,
  input  logic      load_en,
  output piso_act_e act
);

  always_comb begin
    if (shift_en)     act = ACT_SHIFT;
    else if (load_en) act = ACT_LOAD;
    else              act = ACT_HOLD;
  end

endmodule

// File: rtl/piso_cell.sv
module piso_cell
  import piso_pkg::*;
(
  input  piso_act_e act,
  input  logic      cur_bit,
  input  logic      load_bit,
  input  logic      shift_bit,
  output logic      nxt_bit
);

  always_comb begin
    unique case (act)
      ACT_LOAD:  nxt_bit = load_bit;
      ACT_SHIFT: nxt_bit = shift_bit;
      default:   nxt_bit = cur_bit;
    endcase
  end

endmodule

// File: rtl/piso_shift_reg.sv
module piso_shift_reg
  import piso_pkg::*;
#(
  parameter int WIDTH       = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             clr_n,
  input  logic             shift_en,
  input  logic             load_en,
  input  logic [WIDTH-1:0] par_in,
  input  logic             ser_in,
  output logic [WIDTH-1:0] par_out,
  output logic             ser_out
);

  localparam int MSB = WIDTH - 1;

  logic             rst_n_int;
  piso_act_e        act;
  logic [WIDTH-1:0] state_q;
  logic [WIDTH-1:0] state_d;

  piso_rst_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk        (clk),
    .clr_n      (clr_n),
    .rst_n_sync (rst_n_int)
  );

  piso_ctrl u_ctrl (
    .shift_en (shift_en),
    .load_en  (load_en),
    .act      (act)
  );

  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    logic src_bit;
    if (i == MSB) begin : g_top
      assign src_bit = ser_in;
    end else begin : g_low
      assign src_bit = state_q[i+1];
    end
    piso_cell u_cell (
      .act       (act),
      .cur_bit   (state_q[i]),
      .load_bit  (par_in[i]),
      .shift_bit (src_bit),
      .nxt_bit   (state_d[i])
    );
  end

  always_ff @(posedge clk or negedge rst_n_int) begin
    if (!rst_n_int) state_q <= '0;
    else            state_q <= state_d;
  end

  assign par_out = state_q;
  assign ser_out = state_q[0];

  // R1: clear pin low means empty register at every edge
  p_clear_r1: assert property (@(posedge clk) !clr_n |-> par_out == '0)
    else $error("p_clear_r1");

  // R2
  p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n_int)
    (!shift_en && !load_en) |=> $stable(par_out))
    else $error("p_hold_r2");

  // R3
  p_load_r3: assert property (@(posedge clk) disable iff (!rst_n_int)
    (load_en && !shift_en) |=> par_out == $past(par_in))
    else $error("p_load_r3");

  // R4
  p_shift_r4: assert property (@(posedge clk) disable iff (!rst_n_int)
    shift_en |=> par_out[WIDTH-2:0] == $past(par_out[MSB:1]))
    else $error("p_shift_r4");

  // R5: top bit comes from serial input even while load is requested
  p_prio_r5: assert property (@(posedge clk) disable iff (!rst_n_int)
    (shift_en && load_en) |=> par_out[MSB] == $past(ser_in))
    else $error("p_prio_r5");

  // R8: while the synchronized reset is active the register stays empty
  p_release_r8: assert property (@(posedge clk) !rst_n_int |-> par_out == '0)
    else $error("p_release_r8");

endmodule

// File: tb/sim_piso_shift_reg.sv
module sim_piso_shift_reg;

  localparam int W = 4;

  logic         clk = 1'b0;
  logic         clr_n;
  logic         shift_en, load_en, ser_in;
  logic [W-1:0] par_in;
  logic [W-1:0] par_out;
  logic         ser_out;

  int checks = 0;
  int errors = 0;
  int model  = 0;

  always #2 clk = ~clk;

  piso_shift_reg #(.WIDTH(W), .SYNC_STAGES(2)) u0 (
    .clk      (clk),
    .clr_n    (clr_n),
    .shift_en (shift_en),
    .load_en  (load_en),
    .par_in   (par_in),
    .ser_in   (ser_in),
    .par_out  (par_out),
    .ser_out  (ser_out)
  );

  task automatic check(input string req, input int act_v, input int exp_v);
    checks++;
    if (act_v != exp_v) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act_v, exp_v, $time);
    end
  endtask

  // one clock of stimulus, reference update, then compare
  task automatic step(input string req, input logic sh, input logic ld,
                      input int d, input logic si);
    @(negedge clk);
    shift_en = sh; load_en = ld; par_in = d[W-1:0]; ser_in = si;
    @(posedge clk);
    if (sh)      model = (model / 2) + (si ? (1 << (W-1)) : 0);
    else if (ld) model = d % (1 << W);
    #1;
    check(req, int'(par_out), model);
    check("R6", int'(ser_out), model % 2);
  endtask

  initial begin
    #800000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    clr_n = 1'b1; shift_en = 0; load_en = 0; par_in = '0; ser_in = 0;
    #1 clr_n = 1'b0;
    #1;
    check("R1", int'(par_out), 0);
    // R8: release with load held; two ignored edges, third captures
    @(negedge clk);
    load_en = 1; par_in = 4'b1010; clr_n = 1'b1;
    @(posedge clk); #1; check("R8", int'(par_out), 0);
    @(posedge clk); #1; check("R8", int'(par_out), 0);
    @(posedge clk); #1; check("R8", int'(par_out), 10);
    model = 10;
    step("R2", 0, 0, 5, 1);
    step("R2", 0, 0, 15, 0);
    step("R3", 0, 1, 6, 1);
    step("R4", 1, 0, 0, 1);
    step("R4", 1, 0, 9, 0);
    step("R5", 1, 1, 15, 0);
    step("R5", 1, 1, 0, 1);
    // R7: serialise 1011
    step("R7", 0, 1, 11, 1);
    check("R7", int'(par_out[W-1]), 1);
    step("R7", 1, 0, 0, 0);
    check("R7", int'(ser_out), 1); check("R7", int'(par_out[W-1]), 0);
    step("R7", 1, 0, 0, 0);
    check("R7", int'(ser_out), 0); check("R7", int'(par_out[W-1]), 0);
    step("R7", 1, 0, 0, 0);
    check("R7", int'(ser_out), 1); check("R7", int'(par_out[W-1]), 0);
    step("R7", 1, 0, 0, 0);
    check("R7", int'(par_out), 0);
    // varied serial stream
    for (int k = 0; k < 8; k++) step("R4", 1, 0, 0, logic'(k % 3 == 0));
    step("R3", 0, 1, 15, 0);
    // R1: clear between edges
    @(negedge clk);
    shift_en = 0; load_en = 0;
    #1 clr_n = 1'b0;
    #0.5;
    check("R1", int'(par_out), 0);
    check("R6", int'(ser_out), 0);
    @(posedge clk); #1; check("R1", int'(par_out), 0);
    @(negedge clk); clr_n = 1'b1;
    repeat (3) @(posedge clk);
    model = 0;
    step("R2", 0, 0, 7, 1);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule